// File: doc/BRIEF.md
# Inbound Doorbell Receive Queue

This block takes doorbell events that have already been decoded from the link. Each event carries a 16-bit source ID, a 16-bit target ID and a 16-bit info word. The block writes each accepted event as one 8-byte entry into a circular ring of `DEPTH` entries in system memory, using a memory write port. The default ring is 512 entries, or 4 KB. The hardware owns both ring pointers. The enqueue offset moves forward on every write. The dequeue offset moves forward only when software pulses the retire strobe after it has consumed the entry at the dequeue offset.

A status byte reports three conditions, and each bit is write-one-to-clear:
- A doorbell is pending in the queue.
- A doorbell was dropped because the ring was full.
- A reception error occurred.

Each status bit has its own interrupt enable, and the interrupt output follows the enabled bits. When the pending bit is cleared while entries are still waiting, it is raised again at once, so software never loses track of work that is still queued.

Top module: `dbq_rx_queue`

## Requirements
- R1: After synchronous reset, both ring offsets are 0, the status byte is 0x00, `irq` is 0 and `mem_we` is 0.
- R2: An accepted doorbell produces one memory write, with `mem_we` high in the cycle after the event is sampled. `mem_addr` equals the enqueue offset from before the write. `mem_wdata` equals {16'h0000, target, source, info}, with byte 0 in bits 63:56. So the target sits at bytes 2-3, the source at bytes 4-5 and the info at bytes 6-7, each big-endian.
- R3: Each write advances the enqueue offset by 8, modulo DEPTH*8 (4096 by default).
- R4: A retire pulse advances the dequeue offset by 8, modulo DEPTH*8, when at least one entry is pending. When the ring is empty, the pulse has no effect.
- R5: The ring holds DEPTH pending entries. A doorbell that arrives while the ring is full produces no write and leaves the enqueue offset unchanged. It sets status bit 4 (queue full).
- R6: Status bit 0 (doorbell in queue) is set by every write. A write-one-to-clear of bit 0 leaves it set if entries remain pending after that cycle, and clears it if the ring is empty.
- R7: A pulse on `rx_err` sets status bit 7. Writing 1s through the clear port clears the addressed bits, so a mask of 0x91 clears all three. A set in the same cycle as a clear wins.
- R8: `irq` is high when any status bit is set whose enable is on: `irq_en[0]` for bit 0, `irq_en[1]` for bit 4 and `irq_en[2]` for bit 7. `irq` is registered and follows a change one cycle later.
- R9: While `enable` is low, doorbells are ignored. There is no write, no change to the offsets and no change to the status.
- R10: A doorbell and a retire pulse in the same cycle, with the ring neither empty nor full, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Queue enable |
| db_valid | input | 1 | Doorbell event strobe |
| db_tgt | input | 16 | Target ID of the event |
| db_src | input | 16 | Source ID of the event |
| db_info | input | 16 | Info word of the event |
| rx_err | input | 1 | Reception error pulse |
| deq_advance | input | 1 | Retire the entry at the dequeue offset |
| sts_clr_we | input | 1 | Write strobe for the status clear port |
| sts_clr_mask | input | 8 | Write-one-to-clear mask for the status byte |
| irq_en | input | 3 | Interrupt enables for status bits 0, 4 and 7 |
| mem_we | output | 1 | Ring memory write strobe |
| mem_addr | output | 12 | Byte offset of the entry inside the ring |
| mem_wdata | output | 64 | Entry contents |
| enq_ofs | output | 12 | Enqueue byte offset |
| deq_ofs | output | 12 | Dequeue byte offset |
| status | output | 8 | Status byte (bits 7, 4, 0) |
| irq | output | 1 | Interrupt |

## Verification
Several rules are checked on every cycle:
- Each write lands exactly one entry behind the new enqueue offset.
- A write only follows an enabled doorbell.
- The dequeue offset moves only after a retire pulse.
- The pending bit rises only after a doorbell arrives.
- A queue-full event never coincides with a write and never moves the enqueue offset.

Other behaviour can only be shown by the bench's scenarios: the exact entry contents, wrap-around after a full ring, the re-raising of the pending bit after a clear, clear-versus-set ordering, and interrupt masking.

// File: rtl/dbq_pkg.sv
package dbq_pkg;
  localparam int FIELD_W   = 16;
  localparam int ENTRY_W   = 64;
  localparam int STS_ERR   = 7;
  localparam int STS_FULL  = 4;
  localparam int STS_DIQ   = 0;

  function automatic logic [ENTRY_W-1:0] pack_entry(
    input logic [FIELD_W-1:0] tgt,
    input logic [FIELD_W-1:0] src,
    input logic [FIELD_W-1:0] info);
    return {16'h0000, tgt, src, info};
  endfunction
endpackage

// File: rtl/dbq_ptr.sv
module dbq_ptr #(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst)      idx <= '0;
    else if (adv) idx <= idx + 1'b1;
  end
endmodule

// File: rtl/dbq_status.sv
module dbq_status
  import dbq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       set_err,
  input  logic       set_full,
  input  logic       set_diq,
  input  logic       clr_we,
  input  logic [7:0] clr_mask,
  input  logic       still_pending,
  input  logic [2:0] irq_en,
  output logic [7:0] status,
  output logic       irq
);
  logic err_q, full_q, diq_q;
  logic err_d, full_d, diq_d;

  always_comb begin
    err_d  = err_q;
    full_d = full_q;
    diq_d  = diq_q;
    if (clr_we && clr_mask[STS_ERR])  err_d  = 1'b0;
    if (clr_we && clr_mask[STS_FULL]) full_d = 1'b0;
    if (clr_we && clr_mask[STS_DIQ])  diq_d  = still_pending;
    if (set_err)  err_d  = 1'b1;
    if (set_full) full_d = 1'b1;
    if (set_diq)  diq_d  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= 1'b0;
      full_q <= 1'b0;
      diq_q  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      err_q  <= err_d;
      full_q <= full_d;
      diq_q  <= diq_d;
      irq    <= (err_d & irq_en[2]) | (full_d & irq_en[1]) | (diq_d & irq_en[0]);
    end
  end

  always_comb begin
    status           = 8'h00;
    status[STS_ERR]  = err_q;
    status[STS_FULL] = full_q;
    status[STS_DIQ]  = diq_q;
  end
endmodule

// File: rtl/dbq_writer.sv
module dbq_writer
  import dbq_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [OFS_W-1:0]   ofs,
  input  logic [FIELD_W-1:0] tgt,
  input  logic [FIELD_W-1:0] src,
  input  logic [FIELD_W-1:0] info,
  output logic               mem_we,
  output logic [OFS_W-1:0]   mem_addr,
  output logic [ENTRY_W-1:0] mem_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= go;
      if (go) begin
        mem_addr  <= ofs;
        mem_wdata <= pack_entry(tgt, src, info);
      end
    end
  end
endmodule

// File: rtl/dbq_rx_queue.sv
module dbq_rx_queue
  import dbq_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic        db_valid,
  input  logic [15:0] db_tgt,
  input  logic [15:0] db_src,
  input  logic [15:0] db_info,
  input  logic        rx_err,
  input  logic        deq_advance,
  input  logic        sts_clr_we,
  input  logic [7:0]  sts_clr_mask,
  input  logic [2:0]  irq_en,
  output logic        mem_we,
  output logic [11:0] mem_addr,
  output logic [63:0] mem_wdata,
  output logic [11:0] enq_ofs,
  output logic [11:0] deq_ofs,
  output logic [7:0]  status,
  output logic        irq
);
  localparam int ENTRY_BYTES = ENTRY_W / 8;
  localparam int IDX_W       = $clog2(DEPTH);
  localparam int OFS_W       = IDX_W + $clog2(ENTRY_BYTES);
  localparam int CNT_W       = IDX_W + 1;

  logic [IDX_W-1:0] enq_idx, deq_idx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             full, accept, drop, retire;

  assign full   = (cnt == CNT_W'(DEPTH));
  assign accept = enable && db_valid && !full;
  assign drop   = enable && db_valid && full;
  assign retire = deq_advance && (cnt != '0);
  assign cnt_nx = cnt + CNT_W'(accept) - CNT_W'(retire);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nx;
  end

  dbq_ptr #(.IDX_W(IDX_W)) u_enq (
    .clk(clk), .rst(rst), .adv(accept), .idx(enq_idx));

  dbq_ptr #(.IDX_W(IDX_W)) u_deq (
    .clk(clk), .rst(rst), .adv(retire), .idx(deq_idx));

  logic [OFS_W-1:0] enq_byte, deq_byte;
  assign enq_byte = {enq_idx, {($clog2(ENTRY_BYTES)){1'b0}}};
  assign deq_byte = {deq_idx, {($clog2(ENTRY_BYTES)){1'b0}}};
  assign enq_ofs  = 12'(enq_byte);
  assign deq_ofs  = 12'(deq_byte);

  logic [OFS_W-1:0] wr_addr;
  dbq_writer #(.OFS_W(OFS_W)) u_wr (
    .clk(clk), .rst(rst), .go(accept), .ofs(enq_byte),
    .tgt(db_tgt), .src(db_src), .info(db_info),
    .mem_we(mem_we), .mem_addr(wr_addr), .mem_wdata(mem_wdata));
  assign mem_addr = 12'(wr_addr);

  dbq_status u_sts (
    .clk(clk), .rst(rst),
    .set_err(rx_err), .set_full(drop), .set_diq(accept),
    .clr_we(sts_clr_we), .clr_mask(sts_clr_mask),
    .still_pending(cnt_nx != '0), .irq_en(irq_en),
    .status(status), .irq(irq));
endmodule

// File: rtl/dbq_rx_queue_chk.sv
module dbq_rx_queue_chk #(
  parameter int DEPTH = 512
) (
  input logic        clk,
  input logic        rst,
  input logic        enable,
  input logic        db_valid,
  input logic [15:0] db_tgt,
  input logic [15:0] db_src,
  input logic [15:0] db_info,
  input logic        rx_err,
  input logic        deq_advance,
  input logic        sts_clr_we,
  input logic [7:0]  sts_clr_mask,
  input logic [2:0]  irq_en,
  input logic        mem_we,
  input logic [11:0] mem_addr,
  input logic [63:0] mem_wdata,
  input logic [11:0] enq_ofs,
  input logic [11:0] deq_ofs,
  input logic [7:0]  status,
  input logic        irq
);
  localparam logic [11:0] RING_MASK = 12'(DEPTH * 8 - 1);

  // R3
  enq_step_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> enq_ofs == ((mem_addr + 12'd8) & RING_MASK));

  // R9
  write_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(enable && db_valid));

  // R4
  deq_moves_on_retire_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(deq_ofs) |-> $past(deq_advance));

  // R6
  diq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[0]) |-> $past(db_valid && enable));

  // R5
  full_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[4]) |-> (!mem_we && $stable(enq_ofs) && $past(db_valid)));
endmodule

bind dbq_rx_queue dbq_rx_queue_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_dbq_rx_queue.sv
module tb_dbq_rx_queue;
  localparam int DEPTH = 512;
  localparam int RING  = DEPTH * 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0, db_valid = 1'b0, rx_err = 1'b0, deq_advance = 1'b0;
  logic [15:0] db_tgt = '0, db_src = '0, db_info = '0;
  logic        sts_clr_we = 1'b0;
  logic [7:0]  sts_clr_mask = '0;
  logic [2:0]  irq_en = '0;
  logic        mem_we, irq;
  logic [11:0] mem_addr, enq_ofs, deq_ofs;
  logic [63:0] mem_wdata;
  logic [7:0]  status;

  int tests = 0, fails = 0;
  int m_enq = 0, m_deq = 0, m_cnt = 0;
  logic [75:0] sb[$];

  always #10 clk = ~clk;

  dbq_rx_queue #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every memory write
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (sb.size() == 0) chk(0, "R9 unexpected write", {52'd0, mem_addr}, 0);
      else begin
        logic [75:0] e;
        e = sb.pop_front();
        chk(mem_addr == e[75:64], "R2 addr", mem_addr, e[75:64]);
        chk(mem_wdata == e[63:0], "R2 data", mem_wdata, e[63:0]);
      end
    end
  end

  task automatic send(input logic [15:0] t, input logic [15:0] s, input logic [15:0] i);
    @(negedge clk);
    db_valid = 1'b1; db_tgt = t; db_src = s; db_info = i;
    if (enable && m_cnt < DEPTH) begin
      sb.push_back({12'(m_enq), 16'h0000, t, s, i});
      m_enq = (m_enq + 8) % RING;
      m_cnt++;
    end
    @(negedge clk);
    db_valid = 1'b0;
  endtask

  task automatic retire();
    @(negedge clk);
    deq_advance = 1'b1;
    if (m_cnt > 0) begin m_deq = (m_deq + 8) % RING; m_cnt--; end
    @(negedge clk);
    deq_advance = 1'b0;
  endtask

  task automatic w1c(input logic [7:0] m);
    @(negedge clk);
    sts_clr_we = 1'b1; sts_clr_mask = m;
    @(negedge clk);
    sts_clr_we = 1'b0; sts_clr_mask = '0;
  endtask

  task automatic set_ien(input logic [2:0] v);
    @(negedge clk);
    irq_en = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(enq_ofs == 0 && deq_ofs == 0, "R1 offsets", {enq_ofs, deq_ofs}, 0);
    chk(status == 8'h00, "R1 status", status, 0);
    chk(irq == 1'b0 && mem_we == 1'b0, "R1 irq/we", {irq, mem_we}, 0);

    enable = 1'b1;
    set_ien(3'b111);
    send(16'h1234, 16'h00AB, 16'hCAFE);
    send(16'hFFFF, 16'h0000, 16'h8001);
    send(16'h0F0F, 16'hF0F0, 16'h5A5A);
    chk(enq_ofs == 12'd24, "R3 enq after 3", enq_ofs, 24);
    chk(status == 8'h01, "R6 diq set", status, 8'h01);
    chk(irq == 1'b1, "R8 irq on diq", irq, 1);

    retire(); retire();
    chk(deq_ofs == 12'd16, "R4 deq after 2", deq_ofs, 16);
    w1c(8'h01);
    chk(status == 8'h01, "R6 diq re-raised", status, 8'h01);
    retire();
    w1c(8'h01);
    chk(status == 8'h00, "R6 diq cleared empty", status, 0);
    chk(irq == 1'b0, "R8 irq low", irq, 0);
    retire();
    chk(deq_ofs == 12'd24, "R4 retire when empty", deq_ofs, 24);

    enable = 1'b0;
    send(16'hDEAD, 16'hBEEF, 16'h0001);
    chk(enq_ofs == 12'd24 && status == 8'h00, "R9 disabled", {enq_ofs, status}, {12'd24, 8'h00});
    enable = 1'b1;

    send(16'h0001, 16'h0002, 16'h0003);
    // R10: enqueue and retire in the same cycle
    @(negedge clk);
    db_valid = 1'b1; db_tgt = 16'hA5A5; db_src = 16'h5A5A; db_info = 16'h1111;
    deq_advance = 1'b1;
    sb.push_back({12'(m_enq), 16'h0000, 16'hA5A5, 16'h5A5A, 16'h1111});
    m_enq = (m_enq + 8) % RING; m_deq = (m_deq + 8) % RING;
    @(negedge clk);
    db_valid = 1'b0; deq_advance = 1'b0;
    chk(enq_ofs == 12'd40 && deq_ofs == 12'd32, "R10 both", {enq_ofs, deq_ofs}, {12'd40, 12'd32});

    for (int k = 1; k < DEPTH; k++) send(16'(k), 16'(k * 3), 16'(~k));
    chk(enq_ofs == 12'(m_enq), "R3 wrap", enq_ofs, m_enq);
    chk(status == 8'h01, "R5 not yet full flag", status, 8'h01);
    send(16'h7777, 16'h8888, 16'h9999);
    chk(enq_ofs == 12'(m_enq), "R5 drop keeps enq", enq_ofs, m_enq);
    chk(status == 8'h11, "R5 full bit", status, 8'h11);
    chk(sb.size() == 0, "R5 no pending write", sb.size(), 0);

    set_ien(3'b010);
    chk(irq == 1'b1, "R8 irq on full", irq, 1);
    w1c(8'h10);
    @(negedge clk);
    chk(irq == 1'b0 && status == 8'h01, "R8 masked diq", {irq, status}, {1'b0, 8'h01});
    set_ien(3'b000);

    for (int k = 0; k < DEPTH; k++) retire();
    chk(deq_ofs == enq_ofs, "R4 deq wrap meets enq", deq_ofs, enq_ofs);

    @(negedge clk); rx_err = 1'b1;
    @(negedge clk); rx_err = 1'b0;
    chk(status == 8'h81, "R7 err bit", status, 8'h81);
    set_ien(3'b100);
    chk(irq == 1'b1, "R8 irq on err", irq, 1);
    // R7: set wins over clear in the same cycle
    @(negedge clk); rx_err = 1'b1; sts_clr_we = 1'b1; sts_clr_mask = 8'h80;
    @(negedge clk); rx_err = 1'b0; sts_clr_we = 1'b0; sts_clr_mask = '0;
    chk(status[7] == 1'b1, "R7 set beats clear", status, 8'h81);
    w1c(8'h91);
    chk(status == 8'h00, "R7 clear all", status, 0);
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq drops", irq, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule